// File: doc/BRIEF.md
# DMA Channel Register File with Start Gating

This block holds the programming state for seven DMA channels on a 32-bit register bus. Each channel has three word registers: a memory address, a block control word and a channel control word. A shared enable word gives every channel one gate bit. A further plain storage word holds interrupt settings for software.

A transfer is launched only by a write to a channel's control word. That write must set bit 24, and the channel's gate bit in the shared enable word must already be set. In that case the block raises a one-cycle start pulse. The pulse carries the channel index and the channel's three register values to an external transfer engine.

When the engine reports that a channel has finished, the block clears that channel's bit 24. Readback then shows the channel as idle. Channel 5 is not populated: writes to it are discarded and it never starts.

Top module: `dma_chan_regfile`

## Requirements
- R1: After a synchronous reset every readable word reads zero and `start_valid` is low.
- R2: For channel n, the address word sits at byte offset 0x80+0x10·n and the block control word at 0x84+0x10·n. Each holds the last value written to it. Writing either never raises `start_valid`.
- R3: The control word sits at 0x88+0x10·n and reads back the last value written. A write to it raises `start_valid` for exactly the next cycle when both of these hold: the written bit 24 is 1, and bit 3+4·n of the shared enable word is 1. In that cycle `start_chan` is n, `start_ctrl` is the written value, and `start_addr`/`start_bcr` carry the channel's stored words.
- R4: The shared enable word at 0xF0 holds the last value written. A control write with bit 24 set does not start a channel whose enable bit is 0.
- R5: The word at 0xF4 holds the last value written and has no effect on starting.
- R6: Writes to the three words of channel 5 (0xD0, 0xD4, 0xD8) are discarded. Those words read zero, and channel 5 never starts.
- R7: A `done_valid` pulse with `done_chan` = n clears bit 24 of channel n's control word from the next cycle. All other bits of that word are kept.
- R8: If a control write to channel n and a done report for channel n fall in the same cycle, the written value is stored whole, including bit 24.
- R9: A done report for channel 5, or for index 7, changes no register. A done report for channel n leaves every other channel unchanged.
- R10: Any other word offset reads zero, and writes to it change no register and start nothing. Offsets 0x8C+0x10·n are among these. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational readback of the word at `bus_addr` |
| done_valid | input | 1 | Transfer engine reports a finished channel |
| done_chan | input | 3 | Index of the finished channel |
| start_valid | output | 1 | One-cycle transfer launch pulse |
| start_chan | output | 3 | Index of the launched channel |
| start_addr | output | 32 | Launched channel's address word |
| start_bcr | output | 32 | Launched channel's block control word |
| start_ctrl | output | 32 | Launched channel's control word |

## Verification
Two functions can fall in the same cycle: a control word write and a done report for the same channel. The bench provokes this by driving `done_valid` in the cycle of a control write, first with bit 24 set and then with bit 24 clear. It judges the result by reading the control word back, which must show the written value unchanged.

A second overlap is a done report arriving in the same cycle as a start pulse's write for a different channel. For that case the bench checks that the pulse payload is intact and that the other channel's bit 24 is cleared.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    localparam int DW        = 32;
    localparam int GO_BIT    = 24;
    localparam int GATE_BASE = 3;
    localparam int GATE_STEP = 4;

    localparam logic [7:0] CH_BASE_OFS = 8'h80;
    localparam logic [7:0] GATE_OFS    = 8'hF0;
    localparam logic [7:0] IRQ_OFS     = 8'hF4;

    typedef enum logic [1:0] {
        K_ADDR = 2'd0,
        K_BCR  = 2'd1,
        K_CTRL = 2'd2,
        K_NONE = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic [DW-1:0] addr;
        logic [DW-1:0] bcr;
        logic [DW-1:0] ctrl;
    } chan_regs_t;

    function automatic int gate_bit(input int chan);
        return GATE_BASE + GATE_STEP * chan;
    endfunction

    function automatic reg_kind_e kind_of(input logic [1:0] word);
        case (word)
            2'd0:    return K_ADDR;
            2'd1:    return K_BCR;
            2'd2:    return K_CTRL;
            default: return K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode
    import dma_regs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NUM_CH = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] chan_sel,
    output reg_kind_e         kind,
    output logic              gate_sel,
    output logic              irq_sel
);
    localparam int HI_W   = ADDR_W - 4;
    localparam int HI_BASE = int'(CH_BASE_OFS) >> 4;

    always_comb begin
        kind = kind_of(addr[3:2]);
        for (int n = 0; n < NUM_CH; n++) begin
            chan_sel[n] = (addr[ADDR_W-1:4] == HI_W'(HI_BASE + n)) && (kind != K_NONE);
        end
        gate_sel = (addr[ADDR_W-1:2] == GATE_OFS[ADDR_W-1:2]);
        irq_sel  = (addr[ADDR_W-1:2] == IRQ_OFS[ADDR_W-1:2]);
    end
endmodule

// File: rtl/dma_chan_slice.sv
module dma_chan_slice
    import dma_regs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_sel,
    input  reg_kind_e     kind,
    input  logic [DW-1:0] wdata,
    input  logic          gate_on,
    input  logic          done_hit,
    output chan_regs_t    regs,
    output logic          start_q
);
    logic ctrl_wr;
    assign ctrl_wr = wr_sel && (kind == K_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs    <= '0;
            start_q <= 1'b0;
        end else begin
            if (wr_sel && kind == K_ADDR) regs.addr <= wdata;
            if (wr_sel && kind == K_BCR)  regs.bcr  <= wdata;
            if (ctrl_wr)
                regs.ctrl <= wdata;
            else if (done_hit)
                regs.ctrl[GO_BIT] <= 1'b0;
            start_q <= ctrl_wr && wdata[GO_BIT] && gate_on;
        end
    end

    // R7: a done report with no competing write leaves the channel idle
    p_done_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (done_hit && !ctrl_wr) |=> !regs.ctrl[GO_BIT]);

    // R8: a write in the same cycle as done wins
    p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (done_hit && ctrl_wr) |=> (regs.ctrl == $past(wdata)));

    // R2: without a write the address word holds
    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_sel |=> $stable(regs.addr));
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
    import dma_regs_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_CH  = 7,
    parameter int SKIP_CH = 5,
    parameter int CH_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              done_valid,
    input  logic [CH_W-1:0]   done_chan,
    output logic              start_valid,
    output logic [CH_W-1:0]   start_chan,
    output logic [31:0]       start_addr,
    output logic [31:0]       start_bcr,
    output logic [31:0]       start_ctrl
);
    logic [NUM_CH-1:0] chan_sel;
    reg_kind_e         kind;
    logic              gate_sel, irq_sel;
    logic [DW-1:0]     gate_q, irq_q;
    chan_regs_t        regs  [NUM_CH];
    logic [NUM_CH-1:0] pulse;

    dma_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) i_dec (
        .addr     (bus_addr),
        .chan_sel (chan_sel),
        .kind     (kind),
        .gate_sel (gate_sel),
        .irq_sel  (irq_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
            irq_q  <= '0;
        end else begin
            if (bus_wr && gate_sel) gate_q <= bus_wdata;
            if (bus_wr && irq_sel)  irq_q  <= bus_wdata;
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        if (n == SKIP_CH) begin : g_absent
            assign regs[n]  = '0;
            assign pulse[n] = 1'b0;
        end else begin : g_live
            dma_chan_slice i_slice (
                .clk      (clk),
                .rst      (rst),
                .wr_sel   (bus_wr && chan_sel[n]),
                .kind     (kind),
                .wdata    (bus_wdata),
                .gate_on  (gate_q[gate_bit(n)]),
                .done_hit (done_valid && (done_chan == CH_W'(n))),
                .regs     (regs[n]),
                .start_q  (pulse[n])
            );
        end
    end

    always_comb begin
        start_valid = |pulse;
        start_chan  = '0;
        start_addr  = '0;
        start_bcr   = '0;
        start_ctrl  = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (pulse[n]) begin
                start_chan = CH_W'(n);
                start_addr = regs[n].addr;
                start_bcr  = regs[n].bcr;
                start_ctrl = regs[n].ctrl;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (chan_sel[n]) begin
                case (kind)
                    K_ADDR:  bus_rdata = regs[n].addr;
                    K_BCR:   bus_rdata = regs[n].bcr;
                    K_CTRL:  bus_rdata = regs[n].ctrl;
                    default: bus_rdata = '0;
                endcase
            end
        end
        if (gate_sel) bus_rdata = gate_q;
        if (irq_sel)  bus_rdata = irq_q;
    end

    // R3: at most one channel launches per cycle
    p_one_launch_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pulse));

    // R3: a launched control word always carries the go bit
    p_launch_go_r3: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> start_ctrl[GO_BIT]);

    // R6: the absent channel never launches
    p_no_skip_r6: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> (start_chan != CH_W'(SKIP_CH)));

    // R4: a launch needs the gate bit, which no write touched since
    p_gate_r4: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> gate_q[gate_bit(int'(start_chan))]);
endmodule

// File: tb/test_dma_chan_regfile.sv
`timescale 1ns/1ps
module test_dma_chan_regfile;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        done_valid;
    logic [2:0]  done_chan;
    logic        start_valid;
    logic [2:0]  start_chan;
    logic [31:0] start_addr, start_bcr, start_ctrl;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] m_addr [7];
    logic [31:0] m_bcr  [7];
    logic [31:0] m_ctrl [7];
    logic [31:0] m_gate, m_irq;

    always #2.5 clk = ~clk;

    dma_chan_regfile i_dma_chan_regfile (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done_valid(done_valid), .done_chan(done_chan),
        .start_valid(start_valid), .start_chan(start_chan),
        .start_addr(start_addr), .start_bcr(start_bcr), .start_ctrl(start_ctrl)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int hi = int'(a[7:4]);
        int w  = int'(a[3:2]);
        if (a[7:2] == 6'h3C) return m_gate;
        if (a[7:2] == 6'h3D) return m_irq;
        if (hi >= 8 && hi <= 14 && w != 3) begin
            if (w == 0) return m_addr[hi-8];
            if (w == 1) return m_bcr[hi-8];
            return m_ctrl[hi-8];
        end
        return 32'h0;
    endfunction

    task automatic rd(input string req, input logic [7:0] a);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp_read(a));
    endtask

    task automatic cyc(input string req, input bit w, input logic [7:0] a, input logic [31:0] d,
                       input bit dv, input logic [2:0] dc);
        int  hi = int'(a[7:4]);
        int  wk = int'(a[3:2]);
        int  ch = hi - 8;
        bit  chw = w && hi >= 8 && hi <= 14 && wk != 3 && ch != 5;
        bit  ctw = chw && wk == 2;
        bit  exp_go = ctw && d[24] && m_gate[3 + 4*ch];
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d; done_valid = dv; done_chan = dc;
        @(negedge clk);
        bus_wr = 0; done_valid = 0;
        if (chw && wk == 0) m_addr[ch] = d;
        if (chw && wk == 1) m_bcr[ch] = d;
        if (ctw) m_ctrl[ch] = d;
        if (dv && dc < 7 && dc != 5 && !(ctw && int'(dc) == ch)) m_ctrl[dc][24] = 1'b0;
        if (w && a[7:2] == 6'h3C) m_gate = d;
        if (w && a[7:2] == 6'h3D) m_irq = d;
        check({req, " start_valid"}, {31'b0, start_valid}, {31'b0, exp_go});
        if (exp_go) begin
            check({req, " start_chan"}, {29'b0, start_chan}, ch);
            check({req, " start_addr"}, start_addr, m_addr[ch]);
            check({req, " start_bcr"},  start_bcr,  m_bcr[ch]);
            check({req, " start_ctrl"}, start_ctrl, d);
        end
    endtask

    task automatic rd_all(input string req);
        for (int c = 0; c < 7; c++) begin
            rd(req, 8'(8'h80 + 16*c));
            rd(req, 8'(8'h84 + 16*c));
            rd(req, 8'(8'h88 + 16*c));
        end
        rd(req, 8'hF0);
        rd(req, 8'hF4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 7; c++) begin m_addr[c] = 0; m_bcr[c] = 0; m_ctrl[c] = 0; end
        m_gate = 0; m_irq = 0;
        rst = 1; bus_wr = 0; bus_addr = 0; bus_wdata = 0; done_valid = 0; done_chan = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 start_valid", {31'b0, start_valid}, 32'h0);
        rd_all("R1 reset value");

        // R2 R3 R4 R6 R7: sweep every channel, gate state and go bit
        for (int c = 0; c < 7; c++) begin
            for (int g = 0; g < 2; g++) begin
                for (int b = 0; b < 2; b++) begin
                    logic [31:0] gv = g ? (32'h1 << (3 + 4*c)) : ~(32'h1 << (3 + 4*c));
                    logic [31:0] cv = 32'h0000_0201 | (32'(c) << 4) | (32'(b) << 24) | (32'(g) << 28);
                    cyc("R4 gate write", 1, 8'hF0, gv, 0, 0);
                    cyc("R2 addr write", 1, 8'(8'h80 + 16*c), 32'hA000_0000 + 32'(c*256 + g*16 + b), 0, 0);
                    cyc("R2 bcr write",  1, 8'(8'h84 + 16*c), 32'h0010_0000 + 32'(c*16 + g*2 + b), 0, 0);
                    cyc(c == 5 ? "R6 ctrl write" : "R3 ctrl write", 1, 8'(8'h88 + 16*c), cv, 0, 0);
                    rd(c == 5 ? "R6 readback" : "R3 readback", 8'(8'h88 + 16*c));
                    rd("R2 readback", 8'(8'h80 + 16*c));
                    rd("R2 readback", 8'(8'h84 + 16*c));
                    if (b == 1) begin
                        cyc("R7 done", 0, 8'h00, 0, 1, 3'(c));
                        rd("R7 bit cleared", 8'(8'h88 + 16*c));
                    end
                end
            end
        end
        rd_all("R9 sweep state");

        // R8: write and done for the same channel in one cycle
        cyc("R4 gate all", 1, 8'hF0, 32'hFFFF_FFFF, 0, 0);
        cyc("R8 collide go", 1, 8'hA8, 32'h0100_00C3, 1, 3'd2);
        rd("R8 write wins", 8'hA8);
        cyc("R8 collide idle", 1, 8'hA8, 32'h0000_0044, 1, 3'd2);
        rd("R8 write wins", 8'hA8);

        // R9: done for another channel during a launch; done for 5 and 7
        cyc("R3 arm ch1", 1, 8'h98, 32'h0100_0011, 0, 0);
        cyc("R3 arm ch4", 1, 8'hC8, 32'h0100_0077, 1, 3'd1);
        rd("R9 ch1 cleared", 8'h98);
        rd("R9 ch4 kept", 8'hC8);
        cyc("R9 done ch5", 0, 8'h00, 0, 1, 3'd5);
        cyc("R9 done ch7", 0, 8'h00, 0, 1, 3'd7);
        rd_all("R9 unaffected");

        // R5 R10: plain word and unmapped offsets
        cyc("R5 irq write", 1, 8'hF4, 32'h00FF_803F, 0, 0);
        rd("R5 irq readback", 8'hF4);
        cyc("R10 hole write", 1, 8'h8C, 32'h0100_FFFF, 0, 0);
        cyc("R10 low write",  1, 8'h00, 32'h0100_FFFF, 0, 0);
        cyc("R10 high write", 1, 8'hF8, 32'h0100_FFFF, 0, 0);
        cyc("R10 top write",  1, 8'hFC, 32'h0100_FFFF, 0, 0);
        rd("R10 hole read", 8'h8C);
        rd("R10 low read", 8'h00);
        rd("R10 high read", 8'hF8);
        rd("R10 alias bits", 8'hC9);
        rd_all("R10 unchanged");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule